// File: doc/BRIEF.md
# Paged Memory Decoder with Sticky Write-Protect Control

This block sits between a host CPU's memory bus and an add-on interface board that carries an 8K ROM/EEPROM and a set of banked 8K RAM pages. It holds a write-only control byte, loaded by an I/O write whose low address byte is E3h, and uses it together with the paging controller's "paged in" flag to steer memory accesses in the bottom 16K of the address space. The low 8K window (0000h-1FFFh) can show the ROM or a protected system RAM page. The high 8K window (2000h-3FFFh) shows the selected RAM bank.

The control byte carries a force-map bit (bit 7), a sticky system-RAM bit (bit 6) and a bank number (bits 1..0). The force-map bit pages the interface memory in at once and lifts write protection on the ROM area when the board's protect link is removed. The sticky bit makes the system RAM page (bank 3) stand in for the ROM while paged in, and keeps that page read-only. Once set, only a power-on reset clears it. Whenever an interface chip select is active, the block also raises a signal that turns off the host's internal ROM.

Top module: `pgmem_decode`

## Requirements
- R1: The control byte loads on a clock edge with `io_wr` high and `cpu_addr[7:0] == 8'hE3`, whatever `cpu_addr[15:8]` holds. An I/O write to any other low byte leaves every memory decode unchanged.
- R2: After power-on reset the control byte is all zero. Without `paged_in`, no chip select is active.
- R3: Bit 6 (sticky system-RAM bit) stays set after writing 0 to it and after an ordinary reset (`rst_n`). Only `por_n` clears it.
- R4: An ordinary reset clears the force-map bit (bit 7) and the bank number (bits 1..0).
- R5: With the force-map bit set, a strobed access to 0000h-1FFFh asserts `rom_cs` and a strobed access to 2000h-3FFFh asserts `ram_cs` with `ram_bank` equal to the bank bits. This holds whatever `paged_in` and the sticky bit are.
- R6: `mem_we` is high on a ROM-window access only for a write with the force-map bit set and `wp_fitted` low.
- R7: With the force-map bit clear, the sticky bit set and `paged_in` high, 0000h-1FFFh selects RAM bank 3, and `mem_we` stays low for that window.
- R8: In the same mode, 2000h-3FFFh selects the chosen bank. A write is enabled unless that bank is 3.
- R9: With the force-map bit clear, the sticky bit clear and `paged_in` high, 0000h-1FFFh selects the ROM read-only, and writes to 2000h-3FFFh are always enabled.
- R10: With the force-map bit clear and `paged_in` low, or for any address at 4000h or above, no chip select is active and `host_rom_off` is low.
- R11: `host_rom_off` is high exactly when `rom_cs` or `ram_cs` is high. The two selects are never high together, and `ram_bank` reads 0 when `ram_cs` is low.
- R12: No chip select and no write enable are active unless `mem_rd` or `mem_wr` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low; clears all control bits |
| rst_n | input | 1 | Ordinary reset, synchronous, active low; keeps the sticky bit |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data for the control byte |
| io_wr | input | 1 | I/O write strobe |
| mem_rd | input | 1 | Memory read strobe |
| mem_wr | input | 1 | Memory write strobe |
| paged_in | input | 1 | Paged-in flag from the paging controller |
| wp_fitted | input | 1 | Write-protect link fitted (1 = ROM protected) |
| rom_cs | output | 1 | ROM/EEPROM chip select |
| ram_cs | output | 1 | RAM chip select |
| ram_bank | output | 2 | RAM bank number, valid with `ram_cs` |
| mem_we | output | 1 | Write enable for the selected device |
| host_rom_off | output | 1 | Disables the host internal ROM |

## Verification
The clocked checks assume that address, strobes, `paged_in` and `wp_fitted` settle before the rising clock edge and stay stable across it. They also assume that `por_n` is released away from an edge and that no I/O write is issued while `rst_n` is low. The bench drives every input at the falling edge, pulses `io_wr` for exactly one cycle, and issues control writes only while `rst_n` is high. It keeps memory accesses separate from I/O writes, so each decode it samples sees a settled control byte.

// File: rtl/pgmem_pkg.sv
package pgmem_pkg;

  // Which 8K window of the bottom 16K an address falls in
  typedef enum logic [1:0] {
    RG_NONE = 2'd0,
    RG_LOW  = 2'd1,
    RG_HIGH = 2'd2
  } region_e;

  // Active memory map chosen from the control bits and the paging flag
  typedef enum logic [1:0] {
    MODE_OFF    = 2'd0,
    MODE_FORCE  = 2'd1,
    MODE_SYSRAM = 2'd2,
    MODE_ROM    = 2'd3
  } map_mode_e;

endpackage

// File: rtl/pgmem_ctrl_reg.sv
module pgmem_ctrl_reg #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int BANK_W = 2,
  parameter int PORT_W = 8,
  parameter logic [PORT_W-1:0] CTRL_PORT = 8'hE3
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic              io_wr,
  output logic              force_o,
  output logic              sticky_o,
  output logic [BANK_W-1:0] bank_o
);

  localparam int FORCE_BIT  = DATA_W - 1;
  localparam int STICKY_BIT = DATA_W - 2;
  localparam int RSVD_LO    = BANK_W;
  localparam int RSVD_HI    = STICKY_BIT - 1;

  // Only the low address byte takes part in the port match
  function automatic logic port_match(input logic [ADDR_W-1:0] a);
    return a[PORT_W-1:0] == CTRL_PORT;
  endfunction

  logic              ctrl_hit;
  logic              load_en;
  logic              force_q;
  logic              sticky_q;
  logic [BANK_W-1:0] bank_q;
  logic              unused_upper_addr;
  logic              unused_rsvd_bits;

  assign ctrl_hit = io_wr && port_match(cpu_addr);
  assign load_en  = ctrl_hit && rst_n;

  assign unused_upper_addr = ^cpu_addr[ADDR_W-1:PORT_W];
  assign unused_rsvd_bits  = ^cpu_wdata[RSVD_HI:RSVD_LO];

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      force_q  <= 1'b0;
      sticky_q <= 1'b0;
      bank_q   <= '0;
    end else begin
      if (!rst_n) begin
        force_q <= 1'b0;
        bank_q  <= '0;
      end else if (load_en) begin
        force_q <= cpu_wdata[FORCE_BIT];
        bank_q  <= cpu_wdata[BANK_W-1:0];
      end
      // sticky bit: set-only until power-on
      if (load_en && cpu_wdata[STICKY_BIT]) begin
        sticky_q <= 1'b1;
      end
    end
  end

  assign force_o  = force_q;
  assign sticky_o = sticky_q;
  assign bank_o   = bank_q;

  // R3
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
    sticky_q |=> sticky_q);

  // R4
  soft_reset_clr_chk: assert property (@(posedge clk) disable iff (!por_n)
    !rst_n |=> (!force_q && bank_q == '0));

  // R1
  no_stray_load_chk: assert property (@(posedge clk) disable iff (!por_n)
    (rst_n && !ctrl_hit) |=> ($stable(force_q) && $stable(bank_q)));

  // R1
  port_load_chk: assert property (@(posedge clk) disable iff (!por_n)
    (rst_n && ctrl_hit) |=> (force_q == $past(cpu_wdata[FORCE_BIT])
                             && bank_q == $past(cpu_wdata[BANK_W-1:0])));

endmodule

// File: rtl/pgmem_mode_sel.sv
module pgmem_mode_sel
  import pgmem_pkg::*;
(
  input  logic      force_map,
  input  logic      sticky,
  input  logic      paged_in,
  output map_mode_e mode
);

  // Force-map outranks the paging flag; the sticky bit picks the low window
  function automatic map_mode_e pick_mode(input logic f, input logic s,
                                          input logic p);
    if (f)      return MODE_FORCE;
    else if (!p) return MODE_OFF;
    else if (s) return MODE_SYSRAM;
    else        return MODE_ROM;
  endfunction

  assign mode = pick_mode(force_map, sticky, paged_in);

endmodule

// File: rtl/pgmem_addr_map.sv
module pgmem_addr_map
  import pgmem_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int PAGE_W   = 13,
  parameter int BANK_W   = 2,
  parameter int SYS_BANK = 3
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              mem_rd,
  input  logic              mem_wr,
  input  logic              wp_fitted,
  input  map_mode_e         mode,
  input  logic [BANK_W-1:0] bank_sel,
  output logic              rom_cs,
  output logic              ram_cs,
  output logic [BANK_W-1:0] ram_bank,
  output logic              mem_we,
  output logic              host_rom_off
);

  localparam int WIN_TOP = PAGE_W + 1;
  localparam logic [BANK_W-1:0] SYS_ID = BANK_W'(SYS_BANK);

  function automatic region_e region_of(input logic [ADDR_W-1:0] a);
    if (a[ADDR_W-1:WIN_TOP] != '0) return RG_NONE;
    else if (a[PAGE_W])            return RG_HIGH;
    else                           return RG_LOW;
  endfunction

  function automatic logic is_sys(input logic [BANK_W-1:0] b);
    return b == SYS_ID;
  endfunction

  region_e           region;
  logic              strobe;
  logic              sel_rom;
  logic              sel_ram;
  logic [BANK_W-1:0] sel_bank;
  logic              wr_ok;

  assign region = region_of(cpu_addr);
  assign strobe = mem_rd || mem_wr;

  always_comb begin
    sel_rom  = 1'b0;
    sel_ram  = 1'b0;
    sel_bank = '0;
    wr_ok    = 1'b0;
    unique case (mode)
      MODE_FORCE: begin
        if (region == RG_LOW) begin
          sel_rom = 1'b1;
          wr_ok   = !wp_fitted;
        end else if (region == RG_HIGH) begin
          sel_ram  = 1'b1;
          sel_bank = bank_sel;
          wr_ok    = 1'b1;
        end
      end
      MODE_SYSRAM: begin
        if (region == RG_LOW) begin
          sel_ram  = 1'b1;
          sel_bank = SYS_ID;
        end else if (region == RG_HIGH) begin
          sel_ram  = 1'b1;
          sel_bank = bank_sel;
          wr_ok    = !is_sys(bank_sel);
        end
      end
      MODE_ROM: begin
        if (region == RG_LOW) begin
          sel_rom = 1'b1;
        end else if (region == RG_HIGH) begin
          sel_ram  = 1'b1;
          sel_bank = bank_sel;
          wr_ok    = 1'b1;
        end
      end
      default: begin
      end
    endcase
  end

  assign rom_cs       = sel_rom && strobe;
  assign ram_cs       = sel_ram && strobe;
  assign ram_bank     = ram_cs ? sel_bank : '0;
  assign mem_we       = (rom_cs || ram_cs) && mem_wr && wr_ok;
  assign host_rom_off = strobe && (sel_rom || sel_ram);

  // R10
  no_high_sel_chk: assert property (@(posedge clk) disable iff (!por_n)
    (cpu_addr[ADDR_W-1:WIN_TOP] != '0) |-> (!rom_cs && !ram_cs && !host_rom_off));

  // R12
  strobe_gate_chk: assert property (@(posedge clk) disable iff (!por_n)
    (rom_cs || ram_cs || mem_we) |-> (mem_rd || mem_wr));

  // R6
  rom_we_chk: assert property (@(posedge clk) disable iff (!por_n)
    (rom_cs && mem_we) |-> (mode == MODE_FORCE && !wp_fitted && mem_wr));

  // R8
  sys_bank_we_chk: assert property (@(posedge clk) disable iff (!por_n)
    (ram_cs && mem_we && ram_bank == SYS_ID) |-> (mode != MODE_SYSRAM || region == RG_HIGH && !is_sys(bank_sel) ));

  // R7
  sysram_low_chk: assert property (@(posedge clk) disable iff (!por_n)
    (mode == MODE_SYSRAM && cpu_addr < ADDR_W'(1 << PAGE_W) && strobe)
      |-> (ram_cs && ram_bank == SYS_ID && !mem_we));

  // R11
  excl_cs_chk: assert property (@(posedge clk) disable iff (!por_n)
    !(rom_cs && ram_cs) && (host_rom_off == (rom_cs || ram_cs)));

endmodule

// File: rtl/pgmem_decode.sv
module pgmem_decode
  import pgmem_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 8,
  parameter int PAGE_W   = 13,
  parameter int BANK_W   = 2,
  parameter int SYS_BANK = 3
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic              io_wr,
  input  logic              mem_rd,
  input  logic              mem_wr,
  input  logic              paged_in,
  input  logic              wp_fitted,
  output logic              rom_cs,
  output logic              ram_cs,
  output logic [BANK_W-1:0] ram_bank,
  output logic              mem_we,
  output logic              host_rom_off
);

  logic              force_map;
  logic              sticky;
  logic [BANK_W-1:0] bank_sel;
  map_mode_e         mode;

  pgmem_ctrl_reg #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .BANK_W (BANK_W)
  ) u_ctrl (
    .clk       (clk),
    .por_n     (por_n),
    .rst_n     (rst_n),
    .cpu_addr  (cpu_addr),
    .cpu_wdata (cpu_wdata),
    .io_wr     (io_wr),
    .force_o   (force_map),
    .sticky_o  (sticky),
    .bank_o    (bank_sel)
  );

  pgmem_mode_sel u_mode (
    .force_map (force_map),
    .sticky    (sticky),
    .paged_in  (paged_in),
    .mode      (mode)
  );

  pgmem_addr_map #(
    .ADDR_W   (ADDR_W),
    .PAGE_W   (PAGE_W),
    .BANK_W   (BANK_W),
    .SYS_BANK (SYS_BANK)
  ) u_map (
    .clk          (clk),
    .por_n        (por_n),
    .cpu_addr     (cpu_addr),
    .mem_rd       (mem_rd),
    .mem_wr       (mem_wr),
    .wp_fitted    (wp_fitted),
    .mode         (mode),
    .bank_sel     (bank_sel),
    .rom_cs       (rom_cs),
    .ram_cs       (ram_cs),
    .ram_bank     (ram_bank),
    .mem_we       (mem_we),
    .host_rom_off (host_rom_off)
  );

  // R5
  force_low_chk: assert property (@(posedge clk) disable iff (!por_n)
    (force_map && cpu_addr[ADDR_W-1:PAGE_W] == '0 && (mem_rd || mem_wr))
      |-> (rom_cs && host_rom_off));

  // R2
  off_no_sel_chk: assert property (@(posedge clk) disable iff (!por_n)
    (!force_map && !paged_in) |-> (!rom_cs && !ram_cs && !host_rom_off));

endmodule

// File: tb/pgmem_decode_bench.sv
module pgmem_decode_bench;

  logic        clk = 1'b0;
  logic        por_n = 1'b0;
  logic        rst_n = 1'b1;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic        io_wr = 1'b0;
  logic        mem_rd = 1'b0;
  logic        mem_wr = 1'b0;
  logic        paged_in = 1'b0;
  logic        wp_fitted = 1'b1;
  logic        rom_cs, ram_cs, mem_we, host_rom_off;
  logic [1:0]  ram_bank;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  // reference state kept by the bench
  bit       m_force = 0;
  bit       m_sticky = 0;
  bit [1:0] m_bank = 0;

  always #4 clk = ~clk;

  pgmem_decode u_pgmem_decode (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .io_wr(io_wr), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .paged_in(paged_in), .wp_fitted(wp_fitted), .rom_cs(rom_cs),
    .ram_cs(ram_cs), .ram_bank(ram_bank), .mem_we(mem_we),
    .host_rom_off(host_rom_off)
  );

  // packed {rom, ram, bank[1:0], we, off}
  function automatic logic [5:0] predict(input logic [15:0] a, input bit rd,
                                         input bit wr, input bit pg, input bit wpf);
    bit rom = 0, ram = 0, we = 0;
    bit [1:0] bk = 0;
    if (a >= 16'h4000 || !(rd || wr)) return 6'b0;
    if (m_force) begin
      if (a < 16'h2000) begin rom = 1; we = wr && !wpf; end
      else begin ram = 1; bk = m_bank; we = wr; end
    end else if (pg) begin
      if (a < 16'h2000) begin
        if (m_sticky) begin ram = 1; bk = 2'd3; end
        else rom = 1;
      end else begin
        ram = 1; bk = m_bank;
        we = wr && !(m_sticky && m_bank == 2'd3);
      end
    end
    return {rom, ram, bk, we, rom | ram};
  endfunction

  function automatic string tag_of(input logic [15:0] a, input bit rd,
                                   input bit wr, input bit pg);
    if (a >= 16'h4000) return "R10";
    if (!(rd || wr))   return "R12";
    if (m_force)       return (a < 16'h2000 && wr) ? "R6" : "R5";
    if (!pg)           return "R10";
    if (m_sticky)      return (a < 16'h2000) ? "R7" : "R8";
    return "R9";
  endfunction

  task automatic access(input logic [15:0] a, input bit rd, input bit wr,
                        input bit pg, input bit wpf, input string tag);
    logic [5:0] got, exp;
    @(negedge clk);
    cpu_addr = a; mem_rd = rd; mem_wr = wr; paged_in = pg; wp_fitted = wpf;
    #2;
    got = {rom_cs, ram_cs, ram_bank, mem_we, host_rom_off};
    exp = predict(a, rd, wr, pg, wpf);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s addr=%h rd=%0d wr=%0d pg=%0d: got %b exp %b (rom,ram,bank,we,off)",
               tag, a, rd, wr, pg, got, exp);
    end
    mem_rd = 0; mem_wr = 0;
  endtask

  task automatic io_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    mem_rd = 0; mem_wr = 0;
    cpu_addr = a; cpu_wdata = d; io_wr = 1;
    @(negedge clk);
    io_wr = 0;
    if (a[7:0] == 8'hE3) begin
      m_force = d[7];
      m_bank  = d[1:0];
      if (d[6]) m_sticky = 1;
    end
  endtask

  task automatic soft_reset();
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    m_force = 0; m_bank = 0;
  endtask

  task automatic power_on();
    @(negedge clk); por_n = 0;
    @(negedge clk); #1 por_n = 1;
    m_force = 0; m_sticky = 0; m_bank = 0;
  endtask

  task automatic random_phase(input int iters);
    for (int i = 0; i < iters; i++) begin
      int pick = $urandom_range(0, 19);
      if (pick < 3) begin
        logic [15:0] a = 16'($urandom);
        if ($urandom_range(0, 1) == 1) a[7:0] = 8'hE3;
        io_write(a, 8'($urandom));
      end else if (pick == 3) begin
        soft_reset();
      end else begin
        logic [15:0] a = 16'($urandom_range(0, 16'h5FFF));
        int s = $urandom_range(0, 4);
        bit rd = (s < 2), wr = (s >= 2 && s < 4);
        bit pg = 1'($urandom), wpf = 1'($urandom);
        access(a, rd, wr, pg, wpf, tag_of(a, rd, wr, pg));
      end
    end
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    power_on();
    // R2: reset state, nothing selected until paged in
    access(16'h0000, 1, 0, 0, 1, "R2");
    access(16'h2100, 1, 0, 0, 1, "R2");
    access(16'h0038, 1, 0, 1, 1, "R9");
    // R1: upper address byte ignored, force-map takes effect
    io_write(16'h12E3, 8'h80);
    access(16'h0100, 1, 0, 0, 1, "R1");
    access(16'h0100, 0, 1, 0, 0, "R6");
    access(16'h0100, 0, 1, 0, 1, "R6");
    // R1: other port leaves map as is
    io_write(16'h00E2, 8'h00);
    access(16'h0100, 1, 0, 0, 1, "R1");
    access(16'h4000, 1, 0, 1, 1, "R10");
    access(16'h0100, 0, 0, 1, 1, "R12");
    io_write(16'hFFE3, 8'h02);
    access(16'h2100, 1, 0, 0, 1, "R10");
    access(16'h2100, 0, 1, 1, 1, "R9");
    access(16'h0000, 0, 1, 1, 0, "R9");
    // R4: soft reset clears bank
    soft_reset();
    access(16'h3FFF, 0, 1, 1, 1, "R4");
    // R7 / R8: system RAM mode
    io_write(16'h00E3, 8'h43);
    access(16'h0066, 1, 0, 1, 1, "R7");
    access(16'h1FFF, 0, 1, 1, 0, "R7");
    access(16'h2000, 0, 1, 1, 0, "R8");
    // R3: writing 0 keeps sticky bit
    io_write(16'h00E3, 8'h01);
    access(16'h0000, 1, 0, 1, 1, "R3");
    access(16'h2000, 0, 1, 1, 1, "R8");
    soft_reset();
    access(16'h1000, 0, 1, 1, 1, "R3");
    // R5: force-map overrides sticky protection
    io_write(16'h00E3, 8'hC3);
    access(16'h1000, 0, 1, 0, 0, "R5");
    access(16'h3000, 0, 1, 1, 1, "R5");
    // R3: power-on clears sticky bit
    power_on();
    access(16'h0000, 1, 0, 1, 1, "R3");
    random_phase(400);
    power_on();
    random_phase(400);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule